// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block keeps the event status word of one channel of a packet DMA engine. The transmit and receive DMA state machines send single-cycle event pulses. Each pulse sets a sticky flag, and software clears a flag by writing 1 to its bit position. An enable register masks the flags. Two summary bits are formed from the enabled flags: a normal group and an abnormal group. Each summary bit also has its own group enable. The OR of the two summary bits drives a single interrupt line.

When a fatal bus fault occurs, the block latches a 3-bit error-type code next to the flags. A receive length watchdog is also built in. It counts the bytes of each incoming packet from its start-of-packet beat. It raises a timeout event once per packet, on the first beat where the total passes 2048 bytes, or 10240 bytes when jumbo mode is on.

Top module: `dma_irq_status`

## Requirements
- R1: A one-cycle pulse on an event input sets its flag in the status word on the next cycle. The flag positions are: tx done bit 0, tx stopped bit 1, tx no-buffer bit 2, rx done bit 6, rx no-buffer bit 7, rx stopped bit 8, watchdog timeout bit 9, tx early bit 10, rx early bit 11, bus fault bit 12.
- R2: Flags are sticky. A status write clears every flag whose bit in the write data is 1. A 0 leaves the flag unchanged, and write data at bits 14 and 15 has no effect.
- R3: If an event and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R4: Status bit 14, the abnormal summary, is 1 exactly when enable bit 14 is 1 and at least one of flags 1, 7, 8, 10 and 12 is set with its enable bit (same position) also set.
- R5: Status bit 15, the normal summary, is 1 exactly when enable bit 15 is 1 and at least one of flags 0, 2, 6 and 11 is set with its enable bit also set.
- R6: A flag whose enable bit is 0 does not change either summary bit. The `irq` output equals status bit 14 OR status bit 15.
- R7: Status bits 18:16 take the `bus_err_code` value in the cycle where flag 12 goes from 0 to 1. They hold that value while flag 12 stays set, and read 0 once flag 12 is cleared.
- R8: In each packet, the watchdog sets flag 9 exactly once: on the first valid beat where the byte total, counted from the `rx_sop` beat, exceeds 2048 bytes, or 10240 bytes when `jumbo_en` is 1.
- R9: Status bits 3-5, 13 and 19-31 read 0. The enable readback keeps only bits 0-2, 6-8, 10-12, 14 and 15.
- R10: After reset, the status word, the enable register and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_tx_done | input | 1 | Transmit packet complete pulse |
| ev_tx_stop | input | 1 | Transmit process stopped pulse |
| ev_tx_nobuf | input | 1 | Transmit descriptor unavailable pulse |
| ev_rx_done | input | 1 | Receive packet complete pulse |
| ev_rx_nobuf | input | 1 | Receive descriptor unavailable pulse |
| ev_rx_stop | input | 1 | Receive process stopped pulse |
| ev_tx_early | input | 1 | Transmit packet fully moved to FIFO pulse |
| ev_rx_early | input | 1 | First receive buffer filled pulse |
| ev_bus_fault | input | 1 | Fatal bus fault pulse |
| bus_err_code | input | 3 | Bus fault type, sampled with ev_bus_fault |
| rx_beat | input | 1 | Valid receive data beat |
| rx_sop | input | 1 | Beat is first of a packet (qualified by rx_beat) |
| rx_bytes | input | BYTES_W | Valid byte count of the beat |
| jumbo_en | input | 1 | Selects the long packet limit |
| ien_wr | input | 1 | Enable register write strobe |
| ien_wdata | input | 16 | Enable register write data |
| sts_wr | input | 1 | Status write-1-to-clear strobe |
| sts_wdata | input | 16 | Status clear mask |
| sts_rdata | output | 32 | Status word |
| ien_rdata | output | 16 | Enable register readback |
| irq | output | 1 | Channel interrupt |

## Verification
On every cycle, the assertions check the following: an event lands in its flag, a flag persists unless written with 1, the error code stays stable while the fault flag is held, the interrupt stays quiet with both group enables off, and the reserved bits stay 0. The grouping of flags into the two summaries, the set-over-clear rule, and the exact byte where the watchdog fires in standard and jumbo modes depend on the state history. Only the bench's scenarios can show those, by comparing against its cycle model, including the directed runs that stop exactly at each limit.

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int STD_LIMIT   = 2048,
  parameter int JUMBO_LIMIT = 10240,
  parameter int BYTES_W     = 4,
  parameter int CNT_W       = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_tx_done,
  input  logic               ev_tx_stop,
  input  logic               ev_tx_nobuf,
  input  logic               ev_rx_done,
  input  logic               ev_rx_nobuf,
  input  logic               ev_rx_stop,
  input  logic               ev_tx_early,
  input  logic               ev_rx_early,
  input  logic               ev_bus_fault,
  input  logic [2:0]         bus_err_code,
  input  logic               rx_beat,
  input  logic               rx_sop,
  input  logic [BYTES_W-1:0] rx_bytes,
  input  logic               jumbo_en,
  input  logic               ien_wr,
  input  logic [15:0]        ien_wdata,
  input  logic               sts_wr,
  input  logic [15:0]        sts_wdata,
  output logic [31:0]        sts_rdata,
  output logic [15:0]        ien_rdata,
  output logic               irq
);
  localparam logic [15:0] ABN_MASK  = 16'h1582;
  localparam logic [15:0] NRM_MASK  = 16'h0845;
  localparam logic [15:0] FLAG_MASK = ABN_MASK | NRM_MASK | 16'h0200;
  localparam logic [15:0] EN_MASK   = ABN_MASK | NRM_MASK | 16'hC000;
  localparam logic [CNT_W:0] LIM_STD = (CNT_W+1)'(STD_LIMIT);
  localparam logic [CNT_W:0] LIM_JMB = (CNT_W+1)'(JUMBO_LIMIT);

  logic [15:0]      st, en, ev, clr;
  logic [2:0]       code;
  logic [CNT_W-1:0] cnt;
  logic             fired;

  logic [CNT_W:0]   base, sum, limit;
  logic             fired_b, wd_hit, abn, nrm;

  assign limit   = jumbo_en ? LIM_JMB : LIM_STD;
  assign base    = rx_sop ? '0 : {1'b0, cnt};
  assign fired_b = rx_sop ? 1'b0 : fired;
  assign sum     = base + (CNT_W+1)'(rx_bytes);
  assign wd_hit  = rx_beat && !fired_b && (sum > limit);

  assign ev  = {3'b000, ev_bus_fault, ev_rx_early, ev_tx_early, wd_hit,
                ev_rx_stop, ev_rx_nobuf, ev_rx_done, 3'b000,
                ev_tx_nobuf, ev_tx_stop, ev_tx_done};
  assign clr = sts_wr ? sts_wdata : 16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= '0;
      en    <= '0;
      code  <= '0;
      cnt   <= '0;
      fired <= 1'b0;
    end else begin
      st <= ((st & ~clr) | ev) & FLAG_MASK;
      if (ien_wr) en <= ien_wdata & EN_MASK;
      if (ev[12] && !st[12])      code <= bus_err_code;
      else if (clr[12] && !ev[12]) code <= '0;
      if (rx_beat) begin
        fired <= fired_b | wd_hit;
        if (!(fired_b || wd_hit)) cnt <= sum[CNT_W-1:0];
      end
    end
  end

  assign abn = en[14] & (|(st & en & ABN_MASK));
  assign nrm = en[15] & (|(st & en & NRM_MASK));

  assign sts_rdata = {13'b0, code, ({nrm, abn, 14'b0} | st)};
  assign ien_rdata = en;
  assign irq       = abn | nrm;
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_tx_done,
  input logic        sts_wr,
  input logic [15:0] sts_wdata,
  input logic [31:0] sts_rdata,
  input logic [15:0] ien_rdata,
  input logic        irq
);
  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_done |=> sts_rdata[0]);

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rdata[0] && !(sts_wr && sts_wdata[0])) |=> sts_rdata[0]);

  p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rdata[12] && !(sts_wr && sts_wdata[12])) |=> $stable(sts_rdata[18:16]));

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_rdata[15:14] == 2'b00) |-> !irq);

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rdata[31:19] == 13'd0) && !sts_rdata[13] && (sts_rdata[5:3] == 3'd0));
endmodule

bind dma_irq_status dma_irq_status_chk u_chk (.*);

// File: tb/tb_dma_irq_status.sv
module tb_dma_irq_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic ev_tx_done = 0, ev_tx_stop = 0, ev_tx_nobuf = 0, ev_rx_done = 0;
  logic ev_rx_nobuf = 0, ev_rx_stop = 0, ev_tx_early = 0, ev_rx_early = 0;
  logic ev_bus_fault = 0;
  logic [2:0] bus_err_code = 0;
  logic rx_beat = 0, rx_sop = 0, jumbo_en = 0;
  logic [3:0] rx_bytes = 0;
  logic ien_wr = 0, sts_wr = 0;
  logic [15:0] ien_wdata = 0, sts_wdata = 0;
  logic [31:0] sts_rdata;
  logic [15:0] ien_rdata;
  logic irq;

  dma_irq_status dut (.*);

  int vectors = 0, errors = 0;
  string tag = "R1";
  logic [12:0] m_flags = 0;
  logic [15:0] m_en = 0;
  logic [2:0]  m_code = 0;
  int          m_cnt = 0;
  bit          m_fired = 0;
  bit          wd_seen;

  function automatic bit f_abn(logic [12:0] f, logic [15:0] e);
    return e[14] && ((f[1]&&e[1]) || (f[7]&&e[7]) || (f[8]&&e[8]) ||
                     (f[10]&&e[10]) || (f[12]&&e[12]));
  endfunction
  function automatic bit f_nrm(logic [12:0] f, logic [15:0] e);
    return e[15] && ((f[0]&&e[0]) || (f[2]&&e[2]) || (f[6]&&e[6]) || (f[11]&&e[11]));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit a, n;
    a = f_abn(m_flags, m_en);
    n = f_nrm(m_flags, m_en);
    vectors++;
    chk(tag, {19'd0, sts_rdata[12:10], sts_rdata[8:0]}, {19'd0, m_flags[12:10], m_flags[8:0]});
    chk("R8", {31'd0, sts_rdata[9]}, {31'd0, m_flags[9]});
    chk("R4", {31'd0, sts_rdata[14]}, {31'd0, a});
    chk("R5", {31'd0, sts_rdata[15]}, {31'd0, n});
    chk("R6", {31'd0, irq}, {31'd0, a | n});
    chk("R7", {29'd0, sts_rdata[18:16]}, {29'd0, m_code});
    chk("R9", {sts_rdata[31:19], sts_rdata[13], sts_rdata[5:3]}, 17'd0);
    chk("R9", {16'd0, ien_rdata}, {16'd0, m_en});
  endtask

  task automatic tick();
    logic [12:0] ev, clr, nf;
    int base, sum, lim;
    bit fb, hit;
    lim  = jumbo_en ? 10240 : 2048;
    base = rx_sop ? 0 : m_cnt;
    fb   = rx_sop ? 1'b0 : m_fired;
    sum  = base + int'(rx_bytes);
    hit  = rx_beat && !fb && sum > lim;
    ev = '0;
    ev[0] = ev_tx_done;  ev[1] = ev_tx_stop;  ev[2] = ev_tx_nobuf;
    ev[6] = ev_rx_done;  ev[7] = ev_rx_nobuf; ev[8] = ev_rx_stop;
    ev[9] = hit;         ev[10] = ev_tx_early; ev[11] = ev_rx_early;
    ev[12] = ev_bus_fault;
    clr = sts_wr ? sts_wdata[12:0] : '0;
    nf = (m_flags & ~clr) | ev;
    wd_seen = hit;
    @(posedge clk);
    if (ev[12] && !m_flags[12]) m_code = bus_err_code;
    else if (clr[12] && !ev[12]) m_code = 3'd0;
    m_flags = nf;
    if (ien_wr) m_en = ien_wdata & 16'hDDC7;
    if (rx_beat) begin m_cnt = sum; m_fired = fb | hit; end
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    {ev_tx_done, ev_tx_stop, ev_tx_nobuf, ev_rx_done, ev_rx_nobuf,
     ev_rx_stop, ev_tx_early, ev_rx_early, ev_bus_fault} = '0;
    rx_beat = 0; rx_sop = 0; rx_bytes = 0; ien_wr = 0; sts_wr = 0;
  endtask

  task automatic wd_run(bit jm, int lim);
    int hits;
    idle(); jumbo_en = jm; hits = 0;
    for (int i = 0; i < lim / 8; i++) begin
      rx_beat = 1; rx_sop = (i == 0); rx_bytes = 4'd8;
      tick(); hits += wd_seen;
    end
    chk("R8", {31'd0, sts_rdata[9]}, 32'd0);
    rx_sop = 0; rx_bytes = 4'd1; tick(); hits += wd_seen;
    chk("R8", {31'd0, sts_rdata[9]}, 32'd1);
    idle(); sts_wr = 1; sts_wdata = 16'h0200; tick(); idle();
    for (int i = 0; i < 20; i++) begin
      rx_beat = 1; rx_bytes = 4'd8; tick(); hits += wd_seen;
    end
    chk("R8", {31'd0, sts_rdata[9]}, 32'd0);
    chk("R8", hits, 32'd1);
    idle();
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    tag = "R10"; vectors++;
    chk("R10", {sts_rdata, ien_rdata, 15'd0, irq}, 64'd0);
    rst_n = 1;
    @(negedge clk); compare();

    tag = "R1";
    ien_wr = 1; ien_wdata = 16'hFFFF; tick(); idle();
    ev_tx_done = 1; ev_rx_stop = 1; tick(); idle();
    chk("R1", {31'd0, sts_rdata[0] & sts_rdata[8]}, 32'd1);

    tag = "R3";
    ev_tx_done = 1; sts_wr = 1; sts_wdata = 16'h0001; tick(); idle();
    chk("R3", {31'd0, sts_rdata[0]}, 32'd1);

    tag = "R2";
    sts_wr = 1; sts_wdata = 16'h0000; tick(); idle();
    chk("R2", {31'd0, sts_rdata[8]}, 32'd1);
    sts_wr = 1; sts_wdata = 16'hC000; tick(); idle();
    chk("R2", {31'd0, sts_rdata[14]}, 32'd1);
    sts_wr = 1; sts_wdata = 16'hFFFF; tick(); idle();
    chk("R2", sts_rdata, 32'd0);

    tag = "R7";
    ev_bus_fault = 1; bus_err_code = 3'd5; tick(); idle();
    ev_bus_fault = 1; bus_err_code = 3'd2; tick(); idle();
    chk("R7", {29'd0, sts_rdata[18:16]}, 32'd5);
    sts_wr = 1; sts_wdata = 16'h1000; tick(); idle();
    chk("R7", {29'd0, sts_rdata[18:16]}, 32'd0);

    tag = "R6";
    ien_wr = 1; ien_wdata = 16'hC000; ev_tx_stop = 1; ev_rx_done = 1; tick(); idle();
    chk("R6", {31'd0, irq}, 32'd0);
    ien_wr = 1; ien_wdata = 16'h4002; tick(); idle();
    chk("R6", {30'd0, sts_rdata[15:14]}, 32'd1);
    sts_wr = 1; sts_wdata = 16'hFFFF; tick(); idle();

    tag = "R8";
    wd_run(1'b0, 2048);
    wd_run(1'b1, 10240);

    tag = "R1";
    for (int i = 0; i < 20000; i++) begin
      ev_tx_done   = ($urandom_range(7) == 0);
      ev_tx_stop   = ($urandom_range(9) == 0);
      ev_tx_nobuf  = ($urandom_range(9) == 0);
      ev_rx_done   = ($urandom_range(7) == 0);
      ev_rx_nobuf  = ($urandom_range(9) == 0);
      ev_rx_stop   = ($urandom_range(11) == 0);
      ev_tx_early  = ($urandom_range(9) == 0);
      ev_rx_early  = ($urandom_range(9) == 0);
      ev_bus_fault = ($urandom_range(15) == 0);
      bus_err_code = 3'($urandom_range(7));
      rx_beat      = ($urandom_range(1) == 0);
      rx_sop       = rx_beat && ($urandom_range(299) == 0);
      rx_bytes     = 4'($urandom_range(15));
      if ($urandom_range(2999) == 0) jumbo_en = ~jumbo_en;
      ien_wr       = ($urandom_range(39) == 0);
      ien_wdata    = 16'($urandom);
      sts_wr       = ($urandom_range(5) == 0);
      sts_wdata    = 16'($urandom);
      tick();
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule